// File: doc/BRIEF.md
# Two-Slot CPU/Video SRAM Interleaver

This block lets a processor and a display fetch engine share one asynchronous SRAM without any arbitration. It runs on a clock at twice the system rate, so one system cycle is two block clocks. A phase bit alternates on every block clock. The first clock of each pair is the processor slot and the second is the video slot. At a 50 MHz block clock, the system cycle is 40 ns and each SRAM access gets 20 ns. Neither requester can hold up the other, because each owns a fixed half of every system cycle.

During its slot, each port drives the SRAM address and strobes from its own inputs. Read data is captured into a per-port register on the clock edge that closes the slot. The processor holds its request inputs for the whole system cycle. Its read result then stays stable until the next processor read completes. Video reads return data with a one-clock valid flag.

The video return path is a stream with no back-pressure. Data and valid are raised for one clock. The consumer must take them in that clock, because there is no ready input and the slot timing cannot be stretched. The `slot_cpu` output tells both requesters where the slot boundary lies.

Top module: `memslot_mux`

## Requirements
- R1: While `rst` is high and on the first clock after it, `slot_cpu` is 1, the SRAM chip select, read strobe, write strobe and data-drive enable are all 0, `cpu_rdata` and `vid_rdata` are 0, and `vid_valid` is 0.
- R2: `slot_cpu` toggles on every clock after reset is released. 1 marks the processor slot and 0 marks the video slot.
- R3: In a processor slot with `cpu_req`=1, `sram_addr` equals `cpu_addr` and `sram_cs`=1. A read (`cpu_we`=0) sets `sram_rd_en`=1 and `sram_wr_en`=0. A write (`cpu_we`=1) sets `sram_wr_en`=1 and `sram_rd_en`=0.
- R4: In a video slot with `vid_req`=1, `sram_addr` equals `vid_addr`, `sram_cs`=1, `sram_rd_en`=1 and `sram_wr_en`=0.
- R5: `sram_dq_oe` is 1 only in a processor slot carrying a processor write, and then `sram_dq_out` equals `cpu_wdata`. In every video slot, `sram_dq_oe` and `sram_wr_en` are 0.
- R6: After a processor read slot, `cpu_rdata` holds the `sram_dq_in` value present during that slot. It stays unchanged through the following video slot and until the next processor read.
- R7: After a video slot with `vid_req`=1, `vid_rdata` holds the `sram_dq_in` value of that slot. `vid_valid` is 1 for exactly the next clock, which is a processor slot.
- R8: A processor slot with `cpu_req`=0 drives `sram_cs`, `sram_rd_en`, `sram_wr_en` and `sram_dq_oe` low, whatever `cpu_we` is, and leaves `cpu_rdata` unchanged. A processor write also leaves `cpu_rdata` unchanged.
- R9: A video slot with `vid_req`=0 drives no SRAM strobe, raises no `vid_valid`, and leaves `vid_rdata` unchanged.
- R10: Activity on one port never changes the other port's addresses, strobes or captured results. Both ports may be active in the same system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the system rate |
| rst | input | 1 | Synchronous reset, active high |
| slot_cpu | output | 1 | 1 during the processor slot, 0 during the video slot |
| cpu_req | input | 1 | Processor access request, held for the system cycle |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | ADDR_W | Processor SRAM address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Last processor read result, held |
| vid_req | input | 1 | Video fetch request |
| vid_addr | input | ADDR_W | Video fetch address |
| vid_rdata | output | DATA_W | Last video fetch result |
| vid_valid | output | 1 | One-clock flag for a new `vid_rdata` |
| sram_addr | output | ADDR_W | SRAM address |
| sram_cs | output | 1 | SRAM chip select, active high |
| sram_rd_en | output | 1 | SRAM output enable, active high |
| sram_wr_en | output | 1 | SRAM write enable, active high |
| sram_dq_out | output | DATA_W | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Enables the data pad driver; pads float when 0 |
| sram_dq_in | input | DATA_W | Data returned from the SRAM pads |

## Verification
A phase register that slips or sticks would show at once on `slot_cpu`. It would also route the wrong port's address onto `sram_addr` in the very same clock, so the first request of either port exposes it. A capture enable tied to the wrong slot would change `cpu_rdata` in the clock after an idle or video slot, or raise `vid_valid` one clock late or in the wrong slot. A bad data-drive enable would show `sram_dq_oe` high during a read or a video slot on the same clock. Every such fault therefore appears within one system cycle of the stimulus that triggers it.

// File: rtl/memslot_pkg.sv
package memslot_pkg;
  typedef enum logic {
    SLOT_CPU = 1'b0,
    SLOT_VID = 1'b1
  } slot_e;

  typedef struct packed {
    logic cs;
    logic rd;
    logic wr;
  } strobe_t;
endpackage

// File: rtl/memslot_seq.sv
module memslot_seq
  import memslot_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_e phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= SLOT_CPU;
    else     phase <= (phase == SLOT_CPU) ? SLOT_VID : SLOT_CPU;
  end

  p_phase_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst)) |-> (phase != $past(phase)));
endmodule

// File: rtl/memslot_drive.sv
module memslot_drive
  import memslot_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_e             phase,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              vid_req,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [ADDR_W-1:0] sram_addr,
  output strobe_t           strobe,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              cap_cpu,
  output logic              cap_vid
);
  logic cpu_turn;
  assign cpu_turn = (phase == SLOT_CPU);

  always_comb begin
    strobe    = '0;
    sram_addr = '0;
    dq_out    = '0;
    dq_oe     = 1'b0;
    cap_cpu   = 1'b0;
    cap_vid   = 1'b0;
    if (cpu_turn) begin
      if (cpu_req) begin
        sram_addr = cpu_addr;
        strobe.cs = 1'b1;
        strobe.rd = !cpu_we;
        strobe.wr = cpu_we;
        dq_oe     = cpu_we;
        dq_out    = cpu_we ? cpu_wdata : '0;
        cap_cpu   = !cpu_we;
      end
    end else if (vid_req) begin
      sram_addr = vid_addr;
      strobe.cs = 1'b1;
      strobe.rd = 1'b1;
      cap_vid   = 1'b1;
    end
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_turn && !cpu_req) |-> (!strobe.cs && !dq_oe));
  p_vid_readonly_r5: assert property (@(posedge clk) disable iff (rst)
    (!cpu_turn) |-> (!strobe.wr && !dq_oe));
endmodule

// File: rtl/memslot_capture.sv
module memslot_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic              fresh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= cap;
      if (cap) q <= din;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!cap && !$past(rst)) |=> $stable(q));
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    fresh |-> (q == $past(din)));
endmodule

// File: rtl/memslot_mux.sv
module memslot_mux
  import memslot_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              slot_cpu,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              vid_req,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [DATA_W-1:0] vid_rdata,
  output logic              vid_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs,
  output logic              sram_rd_en,
  output logic              sram_wr_en,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  slot_e   phase;
  strobe_t strobe;
  logic    cap_cpu, cap_vid, cpu_fresh;

  memslot_seq u_seq (.clk(clk), .rst(rst), .phase(phase));

  memslot_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst(rst), .phase(phase),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .vid_req(vid_req), .vid_addr(vid_addr),
    .sram_addr(sram_addr), .strobe(strobe), .dq_out(sram_dq_out), .dq_oe(sram_dq_oe),
    .cap_cpu(cap_cpu), .cap_vid(cap_vid)
  );

  memslot_capture #(.DATA_W(DATA_W)) u_cap_cpu (
    .clk(clk), .rst(rst), .cap(cap_cpu), .din(sram_dq_in),
    .q(cpu_rdata), .fresh(cpu_fresh)
  );

  memslot_capture #(.DATA_W(DATA_W)) u_cap_vid (
    .clk(clk), .rst(rst), .cap(cap_vid), .din(sram_dq_in),
    .q(vid_rdata), .fresh(vid_valid)
  );

  assign slot_cpu   = (phase == SLOT_CPU);
  assign sram_cs    = strobe.cs;
  assign sram_rd_en = strobe.rd;
  assign sram_wr_en = strobe.wr;

  p_oe_write_only_r5: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (slot_cpu && sram_wr_en && !sram_rd_en));
  p_vid_valid_slot_r7: assert property (@(posedge clk) disable iff (rst)
    vid_valid |-> (slot_cpu && !$past(slot_cpu)));
  p_vid_single_r7: assert property (@(posedge clk) disable iff (rst)
    vid_valid |=> !vid_valid);
  p_cpu_fresh_slot_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_fresh |-> !slot_cpu);
endmodule

// File: tb/memslot_mux_bench.sv
module memslot_mux_bench;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          slot_cpu, cpu_req, cpu_we, vid_req, vid_valid;
  logic [AW-1:0] cpu_addr, vid_addr, sram_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, vid_rdata, sram_dq_out, sram_dq_in;
  logic          sram_cs, sram_rd_en, sram_wr_en, sram_dq_oe;

  memslot_mux u_memslot_mux (
    .clk(clk), .rst(rst), .slot_cpu(slot_cpu),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .vid_req(vid_req), .vid_addr(vid_addr),
    .vid_rdata(vid_rdata), .vid_valid(vid_valid), .sram_addr(sram_addr),
    .sram_cs(sram_cs), .sram_rd_en(sram_rd_en), .sram_wr_en(sram_wr_en),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // SRAM model: returns an address-derived byte when read, a marker otherwise
  assign sram_dq_in = (sram_cs && sram_rd_en) ? mem_val(sram_addr) : 8'hEE;

  // {cpu_req, cpu_we, cpu_addr, cpu_wdata, vid_req, vid_addr}
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 1'b0, 19'h00012, 8'h00, 1'b1, 19'h40034},
    {1'b1, 1'b1, 19'h00100, 8'hA5, 1'b1, 19'h00200},
    {1'b0, 1'b0, 19'h7FFFF, 8'h00, 1'b1, 19'h7FFFF},
    {1'b1, 1'b0, 19'h0ABCD, 8'h00, 1'b0, 19'h00000},
    {1'b0, 1'b1, 19'h00001, 8'h3C, 1'b0, 19'h00002},
    {1'b1, 1'b1, 19'h7FFFF, 8'hFF, 1'b1, 19'h00000},
    {1'b1, 1'b0, 19'h12345, 8'h00, 1'b1, 19'h54321},
    {1'b1, 1'b0, 19'h00000, 8'h00, 1'b1, 19'h00000}
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] exp_cpu = '0;
  logic [DW-1:0] exp_vid = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Entered at a negedge inside a processor slot; returns at the next one.
  task automatic run_cycle(input logic cr, input logic cw, input logic [AW-1:0] ca,
                           input logic [DW-1:0] cd, input logic vr, input logic [AW-1:0] va);
    cpu_req = cr; cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
    vid_req = vr; vid_addr = va;
    #1;
    chk(slot_cpu == 1'b1, "R2 processor slot", {31'd0, slot_cpu}, 32'd1);
    chk(sram_cs == cr, "R3/R8 cs in processor slot", {31'd0, sram_cs}, {31'd0, cr});
    chk(sram_wr_en == (cr && cw), "R3 wr strobe", {31'd0, sram_wr_en}, {31'd0, cr && cw});
    chk(sram_rd_en == (cr && !cw), "R3 rd strobe", {31'd0, sram_rd_en}, {31'd0, cr && !cw});
    chk(sram_dq_oe == (cr && cw), "R5 drive enable", {31'd0, sram_dq_oe}, {31'd0, cr && cw});
    if (cr) chk(sram_addr == ca, "R3 address", {13'd0, sram_addr}, {13'd0, ca});
    if (cr && cw) chk(sram_dq_out == cd, "R5 write data", {24'd0, sram_dq_out}, {24'd0, cd});
    if (cr && !cw) exp_cpu = mem_val(ca);
    @(posedge clk); @(negedge clk);
    chk(slot_cpu == 1'b0, "R2 video slot", {31'd0, slot_cpu}, 32'd0);
    chk(sram_cs == vr && sram_rd_en == vr, "R4/R9 video strobes", {30'd0, sram_cs, sram_rd_en}, {30'd0, vr, vr});
    chk(!sram_wr_en && !sram_dq_oe, "R5 video slot read-only", {30'd0, sram_wr_en, sram_dq_oe}, 32'd0);
    if (vr) chk(sram_addr == va, "R4 video address", {13'd0, sram_addr}, {13'd0, va});
    chk(cpu_rdata == exp_cpu, "R6 R8 R10 cpu result", {24'd0, cpu_rdata}, {24'd0, exp_cpu});
    chk(vid_valid == 1'b0, "R7 valid not in video slot", {31'd0, vid_valid}, 32'd0);
    if (vr) exp_vid = mem_val(va);
    @(posedge clk); @(negedge clk);
    chk(vid_valid == vr, "R7 R9 valid pulse", {31'd0, vid_valid}, {31'd0, vr});
    chk(vid_rdata == exp_vid, "R7 R9 R10 video result", {24'd0, vid_rdata}, {24'd0, exp_vid});
    chk(cpu_rdata == exp_cpu, "R6 cpu result held", {24'd0, cpu_rdata}, {24'd0, exp_cpu});
  endtask

  task automatic check_reset_state();
    chk(slot_cpu == 1'b1, "R1 slot after reset", {31'd0, slot_cpu}, 32'd1);
    chk({sram_cs, sram_rd_en, sram_wr_en, sram_dq_oe} == 4'b0, "R1 strobes idle",
        {28'd0, sram_cs, sram_rd_en, sram_wr_en, sram_dq_oe}, 32'd0);
    chk(cpu_rdata == '0 && vid_rdata == '0, "R1 results cleared", {16'd0, cpu_rdata, vid_rdata}, 32'd0);
    chk(vid_valid == 1'b0, "R1 valid cleared", {31'd0, vid_valid}, 32'd0);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
    end
  end

  initial begin
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0; vid_req = 0; vid_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      run_cycle(VEC[i][48], VEC[i][47], VEC[i][46:28], VEC[i][27:20], VEC[i][19], VEC[i][18:0]);
    end
    // R8: repeated idle processor slots with a write flag set keep the result
    for (int k = 0; k < 3; k++) run_cycle(1'b0, 1'b1, 19'h00055, 8'h77, 1'b0, 19'h0);
    // R10: video traffic alone must not disturb the held processor result
    run_cycle(1'b0, 1'b0, 19'h0, 8'h0, 1'b1, 19'h0AA55);
    // R1: reset in the middle of traffic
    cpu_req = 1; cpu_we = 0; cpu_addr = 19'h00033; vid_req = 1; vid_addr = 19'h00044;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    cpu_req = 0; vid_req = 0;
    #1;
    check_reset_state();
    exp_cpu = '0; exp_vid = '0;
    rst = 1'b0;
    run_cycle(1'b1, 1'b0, 19'h00F0F, 8'h00, 1'b1, 19'h3F0F0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule